// File: doc/BRIEF.md
# Passive LCD Scan Timing Generator

This block turns a stream of line bytes into the signals a passive matrix LCD panel needs. Each byte taken from the line buffer is cut, most significant bits first, into transfers of 1, 2, 4 or 8 bits. Each transfer is presented on the pixel bus with one pixel clock pulse. When the last transfer of a line has been clocked out, a one-cycle line latch pulse follows at once. A frame marker covers the first line of every frame. An AC polarization output flips once per frame.

Line bytes arrive on a valid/ready stream. The block raises `s_ready` only when it is waiting for the next byte. The source may hold `s_valid` low for any number of cycles. During such a gap the pixel clock rests at its inactive level and no data is lost or repeated. The bus width, clock edge, latch polarity, bytes per line and lines per frame are plain configuration inputs. They are captured while the display is off and applied when it is switched on.

Top module: `lcd_scan_gen`

## Requirements
- R1: `cfg_wsel` picks the pixel bus width: code 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits. Each byte goes out in 8/width transfers, most significant bits first, on `lcd_pix[width-1:0]`. The unused upper bits are 0. Outside a transfer the whole bus is 0.
- R2: Each transfer lasts two clocks. With `cfg_pclk_fall`=0 the pixel clock is low in the first clock and high in the second. With `cfg_pclk_fall`=1 both levels are inverted.
- R3: The line latch is active for exactly one clock. That clock comes directly after the second clock of the last transfer of the line's last byte.
- R4: With `cfg_latch_high`=1 the latch is active high. With 0 it is active low.
- R5: `lcd_fsync` is high for the whole of line 0 of every frame, including that line's latch clock and any wait for bytes.
- R6: `lcd_acpol` is 0 after the display is switched on. It toggles in the cycle after the latch that ends the last line of a frame.
- R7: A frame has `cfg_frame_lines` lines and a line has `cfg_line_bytes` bytes. A value of 0 in either acts as 1.
- R8: `lcd_disp` follows `cfg_en` one clock later. While it is low, every other output is 0, `s_ready` is 0, and the line and byte positions restart from line 0, byte 0. All outputs are 0 in reset.
- R9: `s_ready` is high only while the block waits for a byte. A byte is taken when `s_valid` and `s_ready` are both high at a clock edge. The first transfer of that byte starts on the next clock. During a wait the pixel clock stays inactive and the bus reads 0.
- R10: The configuration inputs are sampled on each clock while the display is off. Changes made while it is on are ignored until it has been switched off and on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Display on request |
| cfg_wsel | input | 2 | Pixel bus width code |
| cfg_pclk_fall | input | 1 | Pixel clock active edge is falling when 1 |
| cfg_latch_high | input | 1 | Line latch active level |
| cfg_line_bytes | input | BC_W | Bytes per line |
| cfg_frame_lines | input | LC_W | Lines per frame |
| s_valid | input | 1 | Line byte valid |
| s_ready | output | 1 | Block waits for a byte |
| s_data | input | 8 | Line byte |
| lcd_pix | output | 8 | Pixel data bus |
| lcd_pclk | output | 1 | Pixel clock |
| lcd_latch | output | 1 | Line latch pulse |
| lcd_fsync | output | 1 | First line marker |
| lcd_acpol | output | 1 | AC polarization |
| lcd_disp | output | 1 | Display enable |

## Verification
Each of the four widths is run against a byte stream whose values change from byte to byte, so a wrong bit order or a wrong slice shows up on the bus. Both pixel clock edges and both latch polarities are used across these runs. Runs with a steady `s_valid` are separated from runs with periodic gaps: the first set pins the exact latch position, and the second shows that stalls neither drop nor repeat a byte. Runs with zero counts and with one line per frame check the boundary behaviour of the frame marker and the polarization toggle. One run changes every configuration input while the display is on, to show the captured values stay in force.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_WIDTHS = 4;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_LOAD,
    ST_SHIFT,
    ST_LATCH
  } scan_st_e;

  typedef struct packed {
    logic [1:0] wsel;
    logic       pclk_fall;
    logic       latch_high;
  } lcd_mode_t;
endpackage

// File: rtl/lcd_cfg_hold.sv
module lcd_cfg_hold
  import lcd_scan_pkg::*;
#(
  parameter int BC_W = 8,
  parameter int LC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  lcd_mode_t       mode_in,
  input  logic [BC_W-1:0] bytes_in,
  input  logic [LC_W-1:0] lines_in,
  output lcd_mode_t       mode_q,
  output logic [BC_W-1:0] last_byte_q,
  output logic [LC_W-1:0] last_line_q
);
  // a zero count behaves as a count of one
  logic [BC_W-1:0] last_byte_d;
  logic [LC_W-1:0] last_line_d;

  always_comb begin
    last_byte_d = (bytes_in == '0) ? '0 : bytes_in - BC_W'(1);
    last_line_d = (lines_in == '0) ? '0 : lines_in - LC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      last_byte_q <= '0;
      last_line_q <= '0;
    end else if (capture) begin
      mode_q      <= mode_in;
      last_byte_q <= last_byte_d;
      last_line_q <= last_line_d;
    end
  end
endmodule

// File: rtl/lcd_pix_shifter.sv
module lcd_pix_shifter
  import lcd_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  input  logic              run,
  input  logic [1:0]        wsel,
  output logic [BYTE_W-1:0] pix,
  output logic              strobe,
  output logic              byte_done
);
  logic [BYTE_W-1:0] sh_q;
  logic [2:0]        tr_q;
  logic              ph_q;
  logic [3:0]        per_byte;
  logic [2:0]        last_tr;
  logic [3:0]        step;
  logic [BYTE_W-1:0] opt [NUM_WIDTHS];

  always_comb begin
    per_byte = 4'd8 >> wsel;
    last_tr  = 3'(per_byte - 4'd1);
    step     = 4'd1 << wsel;
  end

  assign strobe    = run & ph_q;
  assign byte_done = run & ph_q & (tr_q == last_tr);

  // one candidate slice per bus width, most significant bits first
  generate
    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
      localparam int N = 1 << k;
      assign opt[k] = BYTE_W'(sh_q[BYTE_W-1 -: N]);
    end
  endgenerate

  assign pix = run ? opt[wsel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      tr_q <= '0;
      ph_q <= 1'b0;
    end else if (load) begin
      sh_q <= data;
      tr_q <= '0;
      ph_q <= 1'b0;
    end else if (run) begin
      if (!ph_q) begin
        ph_q <= 1'b1;
      end else begin
        ph_q <= 1'b0;
        sh_q <= sh_q << step;
        tr_q <= byte_done ? 3'd0 : tr_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr #(
  parameter int BC_W = 8,
  parameter int LC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            byte_done,
  input  logic            latch_step,
  input  logic [BC_W-1:0] last_byte,
  input  logic [LC_W-1:0] last_line,
  output logic            line_end,
  output logic            line0,
  output logic            acpol
);
  logic [BC_W-1:0] bc_q;
  logic [LC_W-1:0] lc_q;
  logic            ac_q;

  assign line_end = byte_done & (bc_q == last_byte);
  assign line0    = (lc_q == '0);
  assign acpol    = ac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= '0;
      lc_q <= '0;
      ac_q <= 1'b0;
    end else if (clear) begin
      bc_q <= '0;
      lc_q <= '0;
      ac_q <= 1'b0;
    end else begin
      if (byte_done) bc_q <= line_end ? '0 : bc_q + BC_W'(1);
      if (latch_step) begin
        if (lc_q == last_line) begin
          lc_q <= '0;
          ac_q <= ~ac_q;
        end else begin
          lc_q <= lc_q + LC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int BC_W = 8,
  parameter int LC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_wsel,
  input  logic              cfg_pclk_fall,
  input  logic              cfg_latch_high,
  input  logic [BC_W-1:0]   cfg_line_bytes,
  input  logic [LC_W-1:0]   cfg_frame_lines,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  output logic [BYTE_W-1:0] lcd_pix,
  output logic              lcd_pclk,
  output logic              lcd_latch,
  output logic              lcd_fsync,
  output logic              lcd_acpol,
  output logic              lcd_disp
);
  scan_st_e          st_q;
  lcd_mode_t         mode_in, mode_q;
  logic [BC_W-1:0]   last_byte;
  logic [LC_W-1:0]   last_line;
  logic [BYTE_W-1:0] pix_w;
  logic              strobe, byte_done, line_end, line0, acpol;
  logic              on, in_shift, in_latch;
  logic              lat_hi_w, pclk_fall_w;

  assign mode_in  = '{wsel: cfg_wsel, pclk_fall: cfg_pclk_fall, latch_high: cfg_latch_high};
  assign on       = (st_q != ST_OFF);
  assign in_shift = (st_q == ST_SHIFT);
  assign in_latch = (st_q == ST_LATCH);
  assign lat_hi_w    = mode_q.latch_high;
  assign pclk_fall_w = mode_q.pclk_fall;

  lcd_cfg_hold #(.BC_W(BC_W), .LC_W(LC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(st_q == ST_OFF),
    .mode_in(mode_in), .bytes_in(cfg_line_bytes), .lines_in(cfg_frame_lines),
    .mode_q(mode_q), .last_byte_q(last_byte), .last_line_q(last_line)
  );

  lcd_pix_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(s_ready & s_valid), .data(s_data),
    .run(in_shift), .wsel(mode_q.wsel), .pix(pix_w), .strobe(strobe),
    .byte_done(byte_done)
  );

  lcd_scan_ctr #(.BC_W(BC_W), .LC_W(LC_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_en || !on), .byte_done(byte_done),
    .latch_step(in_latch), .last_byte(last_byte), .last_line(last_line),
    .line_end(line_end), .line0(line0), .acpol(acpol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
    end else if (!cfg_en) begin
      st_q <= ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:   st_q <= ST_LOAD;
        ST_LOAD:  if (s_valid) st_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (line_end)       st_q <= ST_LATCH;
          else if (byte_done) st_q <= ST_LOAD;
        end
        ST_LATCH: st_q <= ST_LOAD;
        default:  st_q <= ST_OFF;
      endcase
    end
  end

  assign s_ready   = (st_q == ST_LOAD);
  assign lcd_pix   = pix_w;
  assign lcd_pclk  = on & (mode_q.pclk_fall ^ strobe);
  assign lcd_latch = on & ~(mode_q.latch_high ^ in_latch);
  assign lcd_fsync = on & line0;
  assign lcd_acpol = on & acpol;
  assign lcd_disp  = on;
endmodule

// File: rtl/lcd_scan_gen_chk.sv
module lcd_scan_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       disp,
  input logic [7:0] pix,
  input logic       pclk,
  input logic       latch,
  input logic       fsync,
  input logic       acpol,
  input logic       s_ready,
  input logic       lat_hi,
  input logic       pclk_fall
);
  // R8: outputs rest while the display is off
  p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp |-> (pix == 8'd0 && !pclk && !latch && !fsync && !acpol && !s_ready));

  // R3: latch active for a single clock
  p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp && latch == lat_hi) |=> (!disp || latch != lat_hi));

  // R2: active pixel clock level lasts a single clock
  p_pclk_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp && pclk != pclk_fall) |=> (!disp || pclk == pclk_fall));

  // R9: while waiting for a byte nothing is clocked out
  p_wait_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (pclk == pclk_fall && pix == 8'd0 && latch != lat_hi));

  // R6: polarization only moves right after a latch
  p_acpol_at_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp && $past(disp) && acpol != $past(acpol)) |-> $past(latch == lat_hi));
endmodule

bind lcd_scan_gen lcd_scan_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .disp(lcd_disp), .pix(lcd_pix), .pclk(lcd_pclk),
  .latch(lcd_latch), .fsync(lcd_fsync), .acpol(lcd_acpol), .s_ready(s_ready),
  .lat_hi(lat_hi_w), .pclk_fall(pclk_fall_w)
);

// File: tb/test_lcd_scan_gen.sv
module test_lcd_scan_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_wsel = 2'd0;
  logic       cfg_pclk_fall = 1'b0;
  logic       cfg_latch_high = 1'b1;
  logic [7:0] cfg_line_bytes = 8'd1;
  logic [9:0] cfg_frame_lines = 10'd1;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'd0;
  logic [7:0] lcd_pix;
  logic       lcd_pclk, lcd_latch, lcd_fsync, lcd_acpol, lcd_disp;

  lcd_scan_gen i_lcd_scan_gen (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wsel(cfg_wsel),
    .cfg_pclk_fall(cfg_pclk_fall), .cfg_latch_high(cfg_latch_high),
    .cfg_line_bytes(cfg_line_bytes), .cfg_frame_lines(cfg_frame_lines),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .lcd_pix(lcd_pix), .lcd_pclk(lcd_pclk), .lcd_latch(lcd_latch),
    .lcd_fsync(lcd_fsync), .lcd_acpol(lcd_acpol), .lcd_disp(lcd_disp)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0, cycle = 0, byte_k = 0;
  bit gaps = 1'b0;
  // reference model state: 0 off, 1 wait byte, 2 shifting, 3 latch
  int ms = 0, mw = 0, mfall = 0, mlh = 0, mnb = 1, mnl = 1;
  int mtr = 0, mph = 0, mbc = 0, mlc = 0, mm = 0, msh = 0;

  function automatic int byte_val(int k);
    return (k * 37 + 11) & 255;
  endfunction

  task automatic model_step();
    int nbe, nle;
    if (!rst_n) begin
      ms = 0; mbc = 0; mlc = 0; mm = 0; mtr = 0; mph = 0; msh = 0;
      mw = 0; mfall = 0; mlh = 0;
    end else if (!cfg_en) begin
      ms = 0; mbc = 0; mlc = 0; mm = 0;
    end else begin
      nbe = (mnb == 0) ? 1 : mnb;
      nle = (mnl == 0) ? 1 : mnl;
      case (ms)
        0: begin
          mw = cfg_wsel; mfall = cfg_pclk_fall; mlh = cfg_latch_high;
          mnb = cfg_line_bytes; mnl = cfg_frame_lines;
          ms = 1; mbc = 0; mlc = 0; mm = 0;
        end
        1: if (s_valid) begin msh = s_data; mtr = 0; mph = 0; ms = 2; end
        2: begin
          if (mph == 0) mph = 1;
          else begin
            mph = 0;
            msh = (msh << (1 << mw)) & 255;
            if (mtr == (8 >> mw) - 1) begin
              mtr = 0;
              if (mbc == nbe - 1) begin mbc = 0; ms = 3; end
              else begin mbc++; ms = 1; end
            end else mtr++;
          end
        end
        default: begin
          ms = 1;
          if (mlc == nle - 1) begin mlc = 0; mm ^= 1; end
          else mlc++;
        end
      endcase
    end
  endtask

  task automatic compare();
    int on, e_pix, e_pclk, e_lat, e_fs, e_ac, e_rdy;
    bit bad = 0;
    on     = (ms != 0);
    e_pix  = (ms == 2) ? (msh >> (8 - (1 << mw))) : 0;
    e_pclk = on ? (mfall ^ int'(ms == 2 && mph == 1)) : 0;
    e_lat  = on ? (mlh ? int'(ms == 3) : int'(ms != 3)) : 0;
    e_fs   = on && mlc == 0;
    e_ac   = on ? mm : 0;
    e_rdy  = (ms == 1);
    vectors++;
    if (lcd_pix != e_pix[7:0]) begin bad = 1;
      $display("FAIL R1/R10 pix cyc %0d: got %0h expected %0h", cycle, lcd_pix, e_pix); end
    if (lcd_pclk != e_pclk[0]) begin bad = 1;
      $display("FAIL R2 pclk cyc %0d: got %0d expected %0d", cycle, lcd_pclk, e_pclk); end
    if (lcd_latch != e_lat[0]) begin bad = 1;
      $display("FAIL R3/R4/R7 latch cyc %0d: got %0d expected %0d", cycle, lcd_latch, e_lat); end
    if (lcd_fsync != e_fs[0]) begin bad = 1;
      $display("FAIL R5/R7 fsync cyc %0d: got %0d expected %0d", cycle, lcd_fsync, e_fs); end
    if (lcd_acpol != e_ac[0]) begin bad = 1;
      $display("FAIL R6 acpol cyc %0d: got %0d expected %0d", cycle, lcd_acpol, e_ac); end
    if (lcd_disp != on[0]) begin bad = 1;
      $display("FAIL R8 disp cyc %0d: got %0d expected %0d", cycle, lcd_disp, on); end
    if (s_ready != e_rdy[0]) begin bad = 1;
      $display("FAIL R9 ready cyc %0d: got %0d expected %0d", cycle, s_ready, e_rdy); end
    if (bad) miscompares++;
  endtask

  task automatic cyc();
    bit hs;
    @(negedge clk);
    cycle++;
    hs = (ms == 1) && s_valid && rst_n;
    model_step();
    compare();
    if (hs) byte_k++;
    s_data  = byte_val(byte_k)[7:0];
    s_valid = !(gaps && (cycle % 7 == 3 || cycle % 7 == 4));
  endtask

  task automatic run(int w, int fall, int lh, int nb, int nl, int n, bit g);
    cfg_en = 1'b0;
    repeat (3) cyc();
    cfg_wsel = w[1:0]; cfg_pclk_fall = fall[0]; cfg_latch_high = lh[0];
    cfg_line_bytes = nb[7:0]; cfg_frame_lines = nl[9:0]; gaps = g;
    cyc();
    cfg_en = 1'b1;
    repeat (n) cyc();
  endtask

  initial begin
    repeat (3) cyc();               // R8: reset state
    rst_n = 1'b1;
    run(0, 0, 1, 2, 3, 700, 0);     // R1 R2 R3: 1-bit bus, steady stream
    run(1, 1, 0, 3, 2, 700, 1);     // R1 R4 R9: 2-bit bus, falling edge, gaps
    run(2, 0, 1, 4, 4, 900, 0);     // R1 R5 R6: 4-bit bus
    run(3, 1, 1, 5, 1, 500, 1);     // R1 R6: 8-bit bus, one line per frame
    run(3, 0, 0, 0, 0, 300, 0);     // R7: zero counts act as one
    run(2, 1, 0, 2, 3, 300, 1);     // R10: change settings while on
    cfg_wsel = 2'd0; cfg_pclk_fall = 1'b0; cfg_latch_high = 1'b1;
    cfg_line_bytes = 8'd7; cfg_frame_lines = 10'd9;
    repeat (400) cyc();
    cfg_en = 1'b0;                  // R8: switch off mid line
    repeat (20) cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule